// File: doc/BRIEF.md
# Network Interface Wakeup Dispatch and Control Unit

This block is the command and status front end of a full-duplex serial network interface. A processor task drives it through three kinds of bus write. A start-I/O write raises a task wakeup or starts the transmitter. A control write sets or clears the interface's mode flags. A wakeup-clear strobe drops the wakeups that software raised. The serial datapaths outside the block feed in their own wakeup requests: transmit data needed, and receive data available.

All wakeup causes share one wakeup line. A 2-bit dispatch code tells the woken task which cause to serve, so it can branch four ways in one step. The block also holds the loopback, host-ready relay and discard-mode flags. It emits one-cycle pulses for master reset, last word and transmitter start. It tracks a sticky flag that records the far end having gone down. That flag can only be cleared while the far end is ready again. All outputs are registered and reflect an input one clock edge after it is sampled.

Top module: `netif_cmd_unit`

## Requirements
- R1: After synchronous reset, wake is 0 and disp is 00. Loopback, relay, discard, host_rdy_line and all pulses are 0. status is all ones, because the far-end-was-down flag resets set.
- R2: A start-I/O write decodes only data bits 10 and 9. With both bits set (octal 3000) it raises the control wakeup. With only bit 10 set (octal 2000) it raises the input-start wakeup. With only bit 9 set (octal 1000) it gives a one-cycle tx_start pulse in the next cycle. All other bits are ignored.
- R3: On each clock edge, wake registers the OR of the pending control wakeup, the pending input-start wakeup, rx_avail and tx_req. disp registers the highest-priority pending cause. The order is control (01), then input start (00), then input data (11), then output data (10). With nothing pending, disp is 00.
- R4: wake_clr clears only the control and input-start wakeups. A start-I/O set in the same cycle wins over it.
- R5: Control word 1 gives a one-cycle master_rst pulse. It also clears both software wakeups, even against a same-cycle start-I/O set. It leaves loopback, relay and discard unchanged.
- R6: Control word 2 gives a one-cycle last_word pulse.
- R7: Control words 4 and 5 turn loopback on and off. Control words 6 and 7 turn the host-ready relay on and off.
- R8: Control word octal 2000 sets discard mode. Control word octal 1000 clears it.
- R9: Control word 0, and any value other than 1 to 7, octal 2000 or octal 1000, changes no flag and gives no pulse.
- R10: The far-end-was-down flag is set in every cycle in which far_ready is low. Control word 3 clears it only if far_ready is high in that same cycle.
- R11: status is registered with this layout: bit 2 is far-end-was-down, bit 1 is the inverse of far_ready, bit 0 is the inverse of the relay flag. Every higher bit reads 1.
- R12: host_rdy_line is high only when the relay flag is on and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sio_we | input | 1 | Start-I/O write strobe |
| sio_data | input | DATA_W | Start-I/O bus value |
| wake_clr | input | 1 | Clears the software-raised wakeups |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | DATA_W | Control word |
| tx_req | input | 1 | Transmitter data-request wakeup |
| rx_avail | input | 1 | Receiver data-available wakeup |
| far_ready | input | 1 | Far-end ready line |
| wake | output | 1 | Combined task wakeup |
| disp | output | 2 | Dispatch code for the wakeup cause |
| tx_start | output | 1 | Transmitter start pulse |
| master_rst | output | 1 | Master reset pulse to the datapaths |
| last_word | output | 1 | Last-word pulse to the transmitter |
| loopback | output | 1 | Loopback mode flag |
| host_relay | output | 1 | Host-ready relay flag |
| host_rdy_line | output | 1 | Host-ready line as driven to the far end |
| discard | output | 1 | Discard-mode flag |
| status | output | DATA_W | Status word |

## Verification
A software wakeup stuck set would show as wake staying high with disp 01 or 00 after a wake_clr. It would be visible one edge after the clearing strobe. A wrong priority shows up as a wrong disp code on the first cycle in which two causes are pending together. A mis-decoded control word would change a flag or fire a pulse one cycle after an undefined value. A far-end-was-down flag that clears too easily shows as status bit 2 low right after a clear command that was issued while far_ready was low.

// File: rtl/netif_cmd_pkg.sv
package netif_cmd_pkg;
  localparam int SIO_CTRL_BIT = 10;
  localparam int SIO_OUT_BIT  = 9;

  localparam int CW_NOP        = 0;
  localparam int CW_MRST       = 1;
  localparam int CW_LAST       = 2;
  localparam int CW_CLR_DOWN   = 3;
  localparam int CW_LOOP_ON    = 4;
  localparam int CW_LOOP_OFF   = 5;
  localparam int CW_RELAY_ON   = 6;
  localparam int CW_RELAY_OFF  = 7;
  localparam int CW_DISC_ON    = 'o2000;
  localparam int CW_DISC_OFF   = 'o1000;

  typedef enum logic [1:0] {
    DISP_IN_START = 2'b00,
    DISP_CTRL     = 2'b01,
    DISP_OUT_DATA = 2'b10,
    DISP_IN_DATA  = 2'b11
  } disp_e;

  typedef struct packed {
    logic mrst;
    logic last;
    logic clr_down;
    logic loop_on;
    logic loop_off;
    logic relay_on;
    logic relay_off;
    logic disc_on;
    logic disc_off;
  } ctl_cmd_t;
endpackage

// File: rtl/netif_ctl_decode.sv
module netif_ctl_decode
  import netif_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_data,
  output ctl_cmd_t          cmd
);
  function automatic logic is_code(input logic [DATA_W-1:0] v, input int code);
    return v == DATA_W'(code);
  endfunction

  always_comb begin
    cmd           = '0;
    cmd.mrst      = ctl_we && is_code(ctl_data, CW_MRST);
    cmd.last      = ctl_we && is_code(ctl_data, CW_LAST);
    cmd.clr_down  = ctl_we && is_code(ctl_data, CW_CLR_DOWN);
    cmd.loop_on   = ctl_we && is_code(ctl_data, CW_LOOP_ON);
    cmd.loop_off  = ctl_we && is_code(ctl_data, CW_LOOP_OFF);
    cmd.relay_on  = ctl_we && is_code(ctl_data, CW_RELAY_ON);
    cmd.relay_off = ctl_we && is_code(ctl_data, CW_RELAY_OFF);
    cmd.disc_on   = ctl_we && is_code(ctl_data, CW_DISC_ON);
    cmd.disc_off  = ctl_we && is_code(ctl_data, CW_DISC_OFF);
  end
endmodule

// File: rtl/netif_sio_wake.sv
module netif_sio_wake
  import netif_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sio_we,
  input  logic [DATA_W-1:0] sio_data,
  input  logic              wake_clr,
  input  logic              mrst,
  output logic              ctl_wk_nxt,
  output logic              in_wk_nxt,
  output logic              tx_start
);
  logic ctl_wk_q, in_wk_q;
  logic sel_ctl, sel_in, sel_out;

  assign sel_ctl = sio_we &&  sio_data[SIO_CTRL_BIT] &&  sio_data[SIO_OUT_BIT];
  assign sel_in  = sio_we &&  sio_data[SIO_CTRL_BIT] && !sio_data[SIO_OUT_BIT];
  assign sel_out = sio_we && !sio_data[SIO_CTRL_BIT] &&  sio_data[SIO_OUT_BIT];

  always_comb begin
    ctl_wk_nxt = ctl_wk_q;
    in_wk_nxt  = in_wk_q;
    if (wake_clr) begin
      ctl_wk_nxt = 1'b0;
      in_wk_nxt  = 1'b0;
    end
    if (sel_ctl) ctl_wk_nxt = 1'b1;
    if (sel_in)  in_wk_nxt  = 1'b1;
    if (mrst) begin
      ctl_wk_nxt = 1'b0;
      in_wk_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_wk_q <= 1'b0;
      in_wk_q  <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      ctl_wk_q <= ctl_wk_nxt;
      in_wk_q  <= in_wk_nxt;
      tx_start <= sel_out && !mrst;
    end
  end
endmodule

// File: rtl/netif_wake_dispatch.sv
module netif_wake_dispatch
  import netif_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wk,
  input  logic       in_wk,
  input  logic       rx_avail,
  input  logic       tx_req,
  output logic       wake,
  output logic [1:0] disp
);
  disp_e code;

  always_comb begin
    if (ctl_wk)        code = DISP_CTRL;
    else if (in_wk)    code = DISP_IN_START;
    else if (rx_avail) code = DISP_IN_DATA;
    else if (tx_req)   code = DISP_OUT_DATA;
    else               code = DISP_IN_START;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake <= 1'b0;
      disp <= 2'b00;
    end else begin
      wake <= ctl_wk | in_wk | rx_avail | tx_req;
      disp <= code;
    end
  end
endmodule

// File: rtl/netif_flag_bank.sv
module netif_flag_bank
  import netif_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_cmd_t          cmd,
  input  logic              far_ready,
  output logic              master_rst,
  output logic              last_word,
  output logic              loopback,
  output logic              host_relay,
  output logic              host_rdy_line,
  output logic              discard,
  output logic [DATA_W-1:0] status
);
  localparam int STAT_BITS = 3;

  logic loop_n, relay_n, disc_n, down_q, down_n;
  logic [DATA_W-1:0] status_n;

  always_comb begin
    loop_n  = loopback;
    relay_n = host_relay;
    disc_n  = discard;
    down_n  = down_q;
    if (cmd.loop_on)   loop_n  = 1'b1;
    if (cmd.loop_off)  loop_n  = 1'b0;
    if (cmd.relay_on)  relay_n = 1'b1;
    if (cmd.relay_off) relay_n = 1'b0;
    if (cmd.disc_on)   disc_n  = 1'b1;
    if (cmd.disc_off)  disc_n  = 1'b0;
    if (!far_ready)        down_n = 1'b1;
    else if (cmd.clr_down) down_n = 1'b0;
  end

  assign status_n[2] = down_n;
  assign status_n[1] = !far_ready;
  assign status_n[0] = !relay_n;

  for (genvar i = STAT_BITS; i < DATA_W; i++) begin : g_fill
    assign status_n[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loopback      <= 1'b0;
      host_relay    <= 1'b0;
      discard       <= 1'b0;
      down_q        <= 1'b1;
      host_rdy_line <= 1'b0;
      master_rst    <= 1'b0;
      last_word     <= 1'b0;
      status        <= '1;
    end else begin
      loopback      <= loop_n;
      host_relay    <= relay_n;
      discard       <= disc_n;
      down_q        <= down_n;
      host_rdy_line <= relay_n && !loop_n;
      master_rst    <= cmd.mrst;
      last_word     <= cmd.last;
      status        <= status_n;
    end
  end
endmodule

// File: rtl/netif_cmd_unit.sv
module netif_cmd_unit
  import netif_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sio_we,
  input  logic [DATA_W-1:0] sio_data,
  input  logic              wake_clr,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              tx_req,
  input  logic              rx_avail,
  input  logic              far_ready,
  output logic              wake,
  output logic [1:0]        disp,
  output logic              tx_start,
  output logic              master_rst,
  output logic              last_word,
  output logic              loopback,
  output logic              host_relay,
  output logic              host_rdy_line,
  output logic              discard,
  output logic [DATA_W-1:0] status
);
  ctl_cmd_t cmd;
  logic ctl_wk_nxt, in_wk_nxt;

  netif_ctl_decode #(.DATA_W(DATA_W)) u_dec (
    .ctl_we(ctl_we), .ctl_data(ctl_data), .cmd(cmd)
  );

  netif_sio_wake #(.DATA_W(DATA_W)) u_sio (
    .clk(clk), .rst(rst), .sio_we(sio_we), .sio_data(sio_data),
    .wake_clr(wake_clr), .mrst(cmd.mrst),
    .ctl_wk_nxt(ctl_wk_nxt), .in_wk_nxt(in_wk_nxt), .tx_start(tx_start)
  );

  netif_wake_dispatch u_disp (
    .clk(clk), .rst(rst), .ctl_wk(ctl_wk_nxt), .in_wk(in_wk_nxt),
    .rx_avail(rx_avail), .tx_req(tx_req), .wake(wake), .disp(disp)
  );

  netif_flag_bank #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .cmd(cmd), .far_ready(far_ready),
    .master_rst(master_rst), .last_word(last_word), .loopback(loopback),
    .host_relay(host_relay), .host_rdy_line(host_rdy_line),
    .discard(discard), .status(status)
  );
endmodule

// File: rtl/netif_cmd_unit_chk.sv
module netif_cmd_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sio_we,
  input logic [DATA_W-1:0] sio_data,
  input logic              wake_clr,
  input logic              ctl_we,
  input logic [DATA_W-1:0] ctl_data,
  input logic              tx_req,
  input logic              rx_avail,
  input logic              far_ready,
  input logic              wake,
  input logic [1:0]        disp,
  input logic              tx_start,
  input logic              master_rst,
  input logic              last_word,
  input logic              loopback,
  input logic              host_relay,
  input logic              host_rdy_line,
  input logic              discard,
  input logic [DATA_W-1:0] status
);
  logic is_mrst, is_undef;
  assign is_mrst  = ctl_we && ctl_data == DATA_W'(1);
  assign is_undef = ctl_we && ctl_data > DATA_W'(7) &&
                    ctl_data != DATA_W'('o2000) && ctl_data != DATA_W'('o1000);

  p_ctrl_wake_r2: assert property (@(posedge clk) disable iff (rst)
    (sio_we && sio_data[10] && sio_data[9] && !is_mrst) |=> (wake && disp == 2'b01));

  p_tx_start_r2: assert property (@(posedge clk) disable iff (rst)
    (sio_we && !sio_data[10] && sio_data[9] && !is_mrst) |=> tx_start);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wake_clr && !sio_we && !rx_avail && !tx_req) |=> !wake);

  p_mrst_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    is_mrst |=> (master_rst && $stable(loopback) && $stable(host_relay) && $stable(discard)));

  p_undef_r9: assert property (@(posedge clk) disable iff (rst)
    is_undef |=> ($stable(loopback) && $stable(host_relay) && $stable(discard) &&
                  !master_rst && !last_word));

  p_down_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(status[2]) |-> $past(far_ready && ctl_we && ctl_data == DATA_W'(3)));

  p_fill_r11: assert property (@(posedge clk) disable iff (rst)
    &status[DATA_W-1:3]);

  p_line_r12: assert property (@(posedge clk) disable iff (rst)
    host_rdy_line |-> (host_relay && !loopback));
endmodule

bind netif_cmd_unit netif_cmd_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/netif_cmd_unit_bench.sv
module netif_cmd_unit_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic sio_we = 0, wake_clr = 0, ctl_we = 0, tx_req = 0, rx_avail = 0, far_ready = 1;
  logic [W-1:0] sio_data = '0, ctl_data = '0;
  logic wake, tx_start, master_rst, last_word, loopback, host_relay, host_rdy_line, discard;
  logic [1:0] disp;
  logic [W-1:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_ctl, m_in, m_loop, m_relay, m_disc, m_down = 1;

  always #5 clk = ~clk;

  netif_cmd_unit #(.DATA_W(W)) u_netif_cmd_unit (.*);

  function automatic logic [1:0] exp_disp(bit c, bit i, bit ra, bit tq);
    if (c) return 2'b01;
    if (i) return 2'b00;
    if (ra) return 2'b11;
    if (tq) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [W-1:0] exp_status(bit dn, bit fr, bit rl);
    logic [W-1:0] s = '1;
    s[2] = dn; s[1] = !fr; s[0] = !rl;
    return s;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(bit sw, logic [W-1:0] sd, bit wc, bit cw, logic [W-1:0] cd,
                       bit tq, bit ra, bit fr);
    bit b_out, b_mrst, b_last;
    sio_we = sw; sio_data = sd; wake_clr = wc; ctl_we = cw; ctl_data = cd;
    tx_req = tq; rx_avail = ra; far_ready = fr;
    @(posedge clk);
    b_mrst = cw && cd == 1;
    b_last = cw && cd == 2;
    b_out  = sw && !sd[10] && sd[9] && !b_mrst;
    if (wc) begin m_ctl = 0; m_in = 0; end
    if (sw && sd[10] && sd[9]) m_ctl = 1;
    if (sw && sd[10] && !sd[9]) m_in = 1;
    if (b_mrst) begin m_ctl = 0; m_in = 0; end
    if (cw) begin
      case (cd)
        4: m_loop = 1;
        5: m_loop = 0;
        6: m_relay = 1;
        7: m_relay = 0;
        W'('o2000): m_disc = 1;
        W'('o1000): m_disc = 0;
        default: ;
      endcase
    end
    if (!fr) m_down = 1;
    else if (cw && cd == 3) m_down = 0;
    @(negedge clk);
    chk("R3 wake", W'(wake), W'(m_ctl | m_in | ra | tq));
    chk("R3 disp", W'(disp), W'(exp_disp(m_ctl, m_in, ra, tq)));
    chk("R2 tx_start", W'(tx_start), W'(b_out));
    chk("R5 master_rst", W'(master_rst), W'(b_mrst));
    chk("R6 last_word", W'(last_word), W'(b_last));
    chk("R7 loopback", W'(loopback), W'(m_loop));
    chk("R7 host_relay", W'(host_relay), W'(m_relay));
    chk("R8 discard", W'(discard), W'(m_disc));
    chk("R12 host_rdy_line", W'(host_rdy_line), W'(m_relay && !m_loop));
    chk("R11 R10 status", status, exp_status(m_down, fr, m_relay));
  endtask

  task automatic idle(bit fr = 1);
    cycle(0, '0, 0, 0, '0, 0, 0, fr);
  endtask

  initial begin
    int seed = 32'h1822;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 wake", W'(wake), '0);
    chk("R1 disp", W'(disp), '0);
    chk("R1 flags", W'({loopback, host_relay, discard, host_rdy_line}), '0);
    chk("R1 pulses", W'({tx_start, master_rst, last_word}), '0);
    chk("R1 status", status, '1);
    rst = 0;
    idle(0);                                   // R10 down stays set
    cycle(0, '0, 0, 1, W'(3), 0, 0, 0);        // R10 clear refused, far end down
    cycle(0, '0, 0, 1, W'(3), 0, 0, 1);        // R10 clear accepted
    cycle(1, W'('o3000), 0, 0, '0, 0, 0, 1);   // R2 control wakeup
    cycle(1, W'('o2000), 0, 0, '0, 1, 1, 1);   // R3 control beats others
    cycle(0, '0, 1, 0, '0, 1, 1, 1);           // R4 clear, input data next
    cycle(0, '0, 0, 0, '0, 1, 0, 1);           // R3 output data alone
    cycle(1, W'('o1000), 0, 0, '0, 0, 0, 1);   // R2 tx_start pulse
    cycle(1, W'('o2000), 1, 0, '0, 0, 0, 1);   // R4 set beats clear
    cycle(1, W'('o3000), 0, 1, W'(1), 0, 0, 1);// R5 mrst beats set
    cycle(1, W'('o174777), 0, 0, '0, 0, 0, 1); // R2 other bits ignored
    cycle(0, '0, 0, 1, W'(6), 0, 0, 1);        // R7 relay on
    cycle(0, '0, 0, 1, W'(4), 0, 0, 1);        // R12 loopback holds line off
    cycle(0, '0, 0, 1, W'('o2000), 0, 0, 1);   // R8 discard on
    cycle(0, '0, 0, 1, W'(1), 0, 0, 1);        // R5 flags kept
    cycle(0, '0, 0, 1, W'(0), 0, 0, 1);        // R9 nop
    cycle(0, '0, 0, 1, W'(8), 0, 0, 1);        // R9 undefined
    cycle(0, '0, 0, 1, W'('o3000), 0, 0, 1);   // R9 undefined
    cycle(0, '0, 0, 1, W'(2), 0, 0, 1);        // R6 last word
    cycle(0, '0, 0, 1, W'(5), 0, 0, 1);        // R7 loopback off
    cycle(0, '0, 0, 1, W'('o1000), 0, 0, 1);   // R8 discard off
    cycle(0, '0, 0, 1, W'(7), 0, 0, 1);        // R7 relay off
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] cd, sd;
      int pick = $urandom_range(0, 12);
      cd = (pick < 8) ? W'(pick) : (pick == 8) ? W'('o2000) :
           (pick == 9) ? W'('o1000) : W'($urandom);
      sd = W'($urandom) & W'('o3000);
      if ($urandom_range(0, 3) == 0) sd = W'($urandom);
      cycle($urandom_range(0, 2) == 0, sd, $urandom_range(0, 3) == 0,
            $urandom_range(0, 2) == 0, cd, $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 7) != 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule